// File: doc/BRIEF.md
# Interlocked Flash Mode Control Register

This block is an 8-bit control register on the processor bus that steps one flash bank through its program, erase and verify modes. Software must raise the mode bits in a fixed order: first a software write enable, then a setup or verify bit, then the program or erase pulse bit. Each bit is writable only once the bits ahead of it in that order already hold 1. The register's mode bits drive the flash array directly.

The seven mode bits drop to zero whenever the external flash write-enable pin is low, in either standby state, and whenever the pin is high but software write enable is off. A sticky error flag is kept apart from the mode bits. It is set by a one-cycle error event, it survives software standby, and only power-on reset or hardware standby clear it. While the flag is set, the program and erase bits are held at zero. When on-chip flash is disabled, the register reads as zero and ignores writes.

Top module: `flash_mode_ctl`

## Requirements
- R1: After power-on reset every bit reads 0. A read returns, from bit 7 down to bit 0: error flag, software write enable, erase setup, program setup, erase verify, program verify, erase, program. `rdata` is 0 while `rd_en` is low.
- R2: The software write-enable bit (bit 6) takes the written value only when `fwe_pin` is 1 during the write.
- R3: Bits 5 to 2 take the written value only when `fwe_pin` is 1 and bit 6 already held 1 before the write. A single write cannot set bit 6 together with any of them.
- R4: The erase bit (bit 1) is writable only when bits 6 and 5 were already 1. The program bit (bit 0) is writable only when bits 6 and 4 were already 1.
- R5: Bits 6 to 0 read 0 after any clock edge that sampled `hw_stby`, `sw_stby`, or `fwe_pin` low.
- R6: With `fwe_pin` high, bits 5 to 0 are 0 one edge after bit 6 holds 0.
- R7: The error flag (bit 7) is set one edge after an `err_evt` pulse. Software writes and `sw_stby` leave it unchanged. Only reset or `hw_stby` clears it. `err_prot_o` follows it.
- R8: While the error flag is set, bits 1 and 0 are 0 and writes to them are ignored. Bits 6 to 2 stay writable.
- R9: While `flash_on` is 0, `rdata` is 0x00 and writes change nothing.
- R10: In a write, a bit whose condition is false keeps its old value, and the other bits in the same write whose condition holds still update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| fwe_pin | input | 1 | Flash write-enable pin level |
| flash_on | input | 1 | On-chip flash enabled |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| err_evt | input | 1 | One-cycle flash error event |
| swe_o | output | 1 | Software write enable |
| esu_o | output | 1 | Erase setup |
| psu_o | output | 1 | Program setup |
| ev_o | output | 1 | Erase verify |
| pv_o | output | 1 | Program verify |
| e_o | output | 1 | Erase |
| p_o | output | 1 | Program |
| err_prot_o | output | 1 | Error protection active |

## Verification
The bench writes a gating bit and the bit it gates in one write. A design that judged permission on the new data would accept both bits. It writes erase setup and erase together from a state with setup clear. A design that dropped the whole write, instead of only the denied bit, would lose the setup bit. Software standby is pulsed with the error flag set; a design with a single reset domain would lose the flag. Program, erase and verify writes are tried under error protection, and a design that masked the wrong bits would show them in the read value.

// File: rtl/fmc_pkg.sv
// Package: bit positions and shared types of the flash mode control register.
// Assumes: the register layout is fixed, since software decodes the bit order.
package fmc_pkg;
    localparam int REG_W  = 8;
    localparam int MODE_W = REG_W - 1;
    localparam int B_ERR  = 7;
    localparam int B_SWE  = 6;
    localparam int B_ESU  = 5;
    localparam int B_PSU  = 4;
    localparam int B_EV   = 3;
    localparam int B_PV   = 2;
    localparam int B_E    = 1;
    localparam int B_P    = 0;
    localparam int N_SETUP = 4;
    typedef logic [MODE_W-1:0] mode_vec_t;
endpackage

// File: rtl/fmc_permit.sv
// Module: fmc_permit
// Works out, per mode bit, whether the current bus write may change that bit.
// Assumes: cur holds the register before the write, so a bit set by this
// write cannot open a later bit in the same write.
module fmc_permit
    import fmc_pkg::*;
(
    input  logic      wr_en,
    input  logic      flash_on,
    input  logic      fwe_pin,
    input  logic      err_lock,
    input  mode_vec_t cur,
    output mode_vec_t permit
);
    localparam int SETUP_IDX [N_SETUP] = '{B_ESU, B_PSU, B_EV, B_PV};

    logic base_ok;
    logic gated_ok;

    // Purpose: common condition for any write to take effect.
    assign base_ok  = wr_en & flash_on & fwe_pin;
    // Purpose: software write enable must already be on.
    assign gated_ok = base_ok & cur[B_SWE];

    assign permit[B_SWE] = base_ok;

    // Purpose: one gate per setup or verify bit, each needing software enable.
    for (genvar i = 0; i < N_SETUP; i++) begin : g_setup
        assign permit[SETUP_IDX[i]] = gated_ok;
    end

    // Purpose: pulse bits need their own setup bit and no error protection.
    assign permit[B_E] = gated_ok & cur[B_ESU] & ~err_lock;
    assign permit[B_P] = gated_ok & cur[B_PSU] & ~err_lock;
endmodule

// File: rtl/fmc_mode_bits.sv
// Module: fmc_mode_bits
// Holds the seven mode bits and applies the write mask, the cascade clear
// and the forced clears.
// Assumes: permit comes from fmc_permit; hard_clr merges the standby and pin-low conditions.
module fmc_mode_bits
    import fmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hard_clr,
    input  logic      err_lock,
    input  mode_vec_t permit,
    input  mode_vec_t wdata,
    output mode_vec_t q
);
    mode_vec_t nxt;

    // Purpose: next state from masked write, cascade, error lock and forced clear.
    always_comb begin
        nxt = q;
        for (int i = 0; i < MODE_W; i++) begin
            if (permit[i]) nxt[i] = wdata[i];
        end
        if (!q[B_SWE]) nxt[B_SWE-1:0] = '0;
        if (err_lock) begin
            nxt[B_E] = 1'b0;
            nxt[B_P] = 1'b0;
        end
        if (hard_clr) nxt = '0;
    end

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    p_forced_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> (q == '0));
    p_cascade_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!q[B_SWE]) |=> (q[B_SWE-1:0] == '0));
endmodule

// File: rtl/fmc_err_flag.sv
// Module: fmc_err_flag
// Sticky error flag, reset only by power-on reset or hardware standby.
// Assumes: err_evt is a single-cycle pulse from the error detector.
module fmc_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_stby,
    input  logic err_evt,
    output logic err_q
);
    // Purpose: set on an error event, clear only in its own reset domain.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) err_q <= 1'b0;
        else if (err_evt)      err_q <= 1'b1;
    end

    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt && !hw_stby) |=> err_q);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !hw_stby) |=> err_q);
endmodule

// File: rtl/flash_mode_ctl.sv
// Module: flash_mode_ctl
// Interlocked flash mode control register: bus access, write permission
// chain, forced clears and sticky error protection for one flash bank.
// Assumes: rst_n is the power-on reset; rdata is combinational during rd_en.
module flash_mode_ctl
    import fmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             fwe_pin,
    input  logic             flash_on,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic             err_evt,
    output logic             swe_o,
    output logic             esu_o,
    output logic             psu_o,
    output logic             ev_o,
    output logic             pv_o,
    output logic             e_o,
    output logic             p_o,
    output logic             err_prot_o
);
    mode_vec_t mode_q;
    mode_vec_t permit;
    logic      err_q;
    logic      err_lock;
    logic      hard_clr;

    // Purpose: conditions that wipe all mode bits regardless of writes.
    assign hard_clr = hw_stby | sw_stby | ~fwe_pin;
    // Purpose: lock the pulse bits from the error event's edge onward.
    assign err_lock = err_q | err_evt;

    fmc_permit u_permit (
        .wr_en    (wr_en),
        .flash_on (flash_on),
        .fwe_pin  (fwe_pin),
        .err_lock (err_lock),
        .cur      (mode_q),
        .permit   (permit)
    );

    fmc_mode_bits u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .hard_clr (hard_clr),
        .err_lock (err_lock),
        .permit   (permit),
        .wdata    (wdata[MODE_W-1:0]),
        .q        (mode_q)
    );

    fmc_err_flag u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .err_evt (err_evt),
        .err_q   (err_q)
    );

    // Purpose: read path, zero when idle or when flash is disabled.
    assign rdata = (rd_en && flash_on) ? {err_q, mode_q} : '0;

    // Purpose: fan individual mode bits out to the flash array.
    assign swe_o      = mode_q[B_SWE];
    assign esu_o      = mode_q[B_ESU];
    assign psu_o      = mode_q[B_PSU];
    assign ev_o       = mode_q[B_EV];
    assign pv_o       = mode_q[B_PV];
    assign e_o        = mode_q[B_E];
    assign p_o        = mode_q[B_P];
    assign err_prot_o = err_q;

    p_swe_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swe_o) |-> $past(fwe_pin && wr_en && flash_on));
    p_setup_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(esu_o) || $rose(psu_o) || $rose(ev_o) || $rose(pv_o)) |-> $past(swe_o));
    p_erase_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_o) |-> $past(esu_o && swe_o && !err_prot_o));
    p_prog_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_o) |-> $past(psu_o && swe_o && !err_prot_o));
    p_err_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_prot_o |-> (!e_o && !p_o));
    p_off_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_on && !hard_clr && swe_o && !err_evt) |=> $stable({swe_o, esu_o, psu_o, ev_o, pv_o}));
endmodule

// File: tb/flash_mode_ctl_tb.sv
module flash_mode_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       fwe_pin = 1'b1, flash_on = 1'b1;
    logic       hw_stby = 1'b0, sw_stby = 1'b0, err_evt = 1'b0;
    logic       swe_o, esu_o, psu_o, ev_o, pv_o, e_o, p_o, err_prot_o;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    flash_mode_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .fwe_pin(fwe_pin), .flash_on(flash_on),
        .hw_stby(hw_stby), .sw_stby(sw_stby), .err_evt(err_evt),
        .swe_o(swe_o), .esu_o(esu_o), .psu_o(psu_o), .ev_o(ev_o), .pv_o(pv_o),
        .e_o(e_o), .p_o(p_o), .err_prot_o(err_prot_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] exp);
        rd_en = 1'b1;
        #1;
        check(tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic wipe();
        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk); hw_stby = 1'b0;
    endtask

    task automatic t_reset_r1();
        rd_chk("R1 reset value", 8'h00);
        check("R1 idle read zero", rdata, 8'h00);
        check("R1 outputs", {err_prot_o, swe_o, esu_o, psu_o, ev_o, pv_o, e_o, p_o}, 8'h00);
    endtask

    task automatic t_swe_r2();
        @(negedge clk); fwe_pin = 1'b0;
        wr(8'h40);
        rd_chk("R2 swe blocked by pin low", 8'h00);
        fwe_pin = 1'b1;
        wr(8'h40);
        rd_chk("R2 swe set with pin high", 8'h40);
        check("R2 swe_o", {7'd0, swe_o}, 8'h01);
    endtask

    task automatic t_setup_r3();
        wipe();
        wr(8'h60);
        rd_chk("R3 same-write gate denied", 8'h40);
        wr(8'h7C);
        rd_chk("R3 setup and verify set", 8'h7C);
    endtask

    task automatic t_pulse_r4();
        wipe();
        wr(8'h40);
        wr(8'h43);
        rd_chk("R4 pulse bits need setup", 8'h40);
        wr(8'h62);
        rd_chk("R10 partial write keeps denied bit", 8'h60);
        wr(8'h70);
        wr(8'h73);
        rd_chk("R4 pulse bits set after setup", 8'h73);
        check("R4 e_o p_o", {6'd0, e_o, p_o}, 8'h03);
    endtask

    task automatic t_clear_r5();
        wr(8'h7C);
        @(negedge clk); sw_stby = 1'b1;
        @(negedge clk); sw_stby = 1'b0;
        rd_chk("R5 software standby clear", 8'h00);
        wr(8'h40); wr(8'h7C);
        @(negedge clk); fwe_pin = 1'b0;
        @(negedge clk); fwe_pin = 1'b1;
        rd_chk("R5 pin low clear", 8'h00);
        wr(8'h40); wr(8'h7C);
        wipe();
        rd_chk("R5 hardware standby clear", 8'h00);
    endtask

    task automatic t_cascade_r6();
        wr(8'h40); wr(8'h7C);
        wr(8'h3C);
        idle(1);
        rd_chk("R6 lower bits drop after swe off", 8'h00);
    endtask

    task automatic t_err_r7();
        @(negedge clk); err_evt = 1'b1;
        @(negedge clk); err_evt = 1'b0;
        rd_chk("R7 error flag set", 8'h80);
        check("R7 err_prot_o", {7'd0, err_prot_o}, 8'h01);
        wr(8'h00);
        rd_chk("R7 write cannot clear flag", 8'h80);
        @(negedge clk); sw_stby = 1'b1;
        @(negedge clk); sw_stby = 1'b0;
        rd_chk("R7 software standby keeps flag", 8'h80);
        wipe();
        rd_chk("R7 hardware standby clears flag", 8'h00);
    endtask

    task automatic t_lock_r8();
        wr(8'h40); wr(8'h70); wr(8'h73);
        rd_chk("R8 armed before error", 8'h73);
        @(negedge clk); err_evt = 1'b1;
        @(negedge clk); err_evt = 1'b0;
        rd_chk("R8 pulse bits forced off", 8'hF0);
        wr(8'h73);
        rd_chk("R8 pulse writes ignored", 8'hF0);
        wr(8'h7C);
        rd_chk("R8 verify still writable", 8'hFC);
    endtask

    task automatic t_off_r9();
        @(negedge clk); flash_on = 1'b0;
        rd_chk("R9 read zero while disabled", 8'h00);
        wr(8'h40);
        flash_on = 1'b1;
        rd_chk("R9 disabled write ignored", 8'hFC);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset_r1();
        t_swe_r2();
        t_setup_r3();
        t_pulse_r4();
        t_clear_r5();
        t_cascade_r6();
        t_err_r7();
        t_lock_r8();
        t_off_r9();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule